// File: doc/BRIEF.md
# Control-Transfer Next-PC Unit

This block resolves where instruction fetch goes next for the control-transfer operations of a 32-bit in-order core. For each valid request it takes the current program counter, the two source register values, the 16-bit branch displacement field, the 26-bit jump index field, the destination register index and a 4-bit operation code. It returns the next program counter, a flag saying whether control leaves the sequential path, and a link-write request (enable, register index, value). The result is registered and appears one clock after the request.

Conditional branches either compare the two source registers or test the first source against zero. Their taken target is the address of the delay slot (PC+4) plus the displacement field scaled by four and sign-extended. Absolute jumps keep the top four bits of the current PC and splice in the jump index scaled by four. Register jumps go to the first source value. Every linking form returns PC+8, the address past the delay slot. The fetch pipeline itself, including the delay-slot sequencing, sits outside this block.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the registered outputs `out_valid`, `next_pc`, `taken`, `link_we`, `link_idx` and `link_val` are all zero after that edge.
- R2: `out_valid` equals `in_valid` one clock earlier. A cycle with `in_valid` low leaves `next_pc`, `taken`, `link_we`, `link_idx` and `link_val` unchanged.
- R3: For a branch operation, the taken target is PC+4 plus the 16-bit field shifted left by two and sign-extended to 32 bits. A branch that is not taken gives `next_pc` = PC+4 with `taken` = 0.
- R4: Op 1 (branch if equal) is taken when `rs_val` equals `rt_val`. Op 2 (branch if not equal) is taken when they differ. A compare against zero uses op 2 with `rt_val` = 0.
- R5: The signed zero tests are op 3 (taken if rs ≤ 0), op 4 (taken if rs > 0), op 5 (taken if rs < 0) and op 6 (taken if rs ≥ 0).
- R6: Op 9 (jump) and op 10 (jump and link) set `taken` = 1 and `next_pc` = {PC[31:28], index, 2'b00}.
- R7: Op 11 (register jump) and op 12 (register jump and link) set `taken` = 1 and `next_pc` = `rs_val`.
- R8: Op 7 (branch if rs < 0 and link), op 8 (branch if rs ≥ 0 and link) and op 10 raise `link_we` with `link_idx` = 31. Op 12 raises `link_we` with `link_idx` = `rd_idx`. In every case `link_val` = PC+8, and for ops 7 and 8 the link is written whether or not the branch is taken.
- R9: Op 0 (sequential) and the unused codes 13 to 15 give `next_pc` = PC+4, `taken` = 0 and `link_we` = 0. Every operation other than 7, 8, 10 and 12 gives `link_we` = 0.
- R10: All address arithmetic wraps modulo 2^32. For example, PC = 0xFFFFFFFC with op 0 gives `next_pc` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 4 | Operation code (see requirements) |
| pc | input | 32 | Address of the control-transfer instruction |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| br_off | input | 16 | Branch displacement field, in words |
| j_idx | input | 26 | Absolute jump index field, in words |
| rd_idx | input | 5 | Destination register for the register jump with link |
| out_valid | output | 1 | Result valid |
| next_pc | output | 32 | Address to fetch next |
| taken | output | 1 | Control leaves the sequential path |
| link_we | output | 1 | Link register write request |
| link_idx | output | 5 | Register that receives the link |
| link_val | output | 32 | Return address (PC+8) |

## Verification
On every cycle the assertions check the following: the reset values; the one-cycle valid timing; holding the result while idle; the PC+8 link value and the register it goes to; the register-jump target; that an absolute jump keeps its region bits; and the equality decision. Some behaviour only the bench scenarios can show. These are the exact branch targets at the displacement extremes, the signed boundaries of the zero tests at 0, -1 and the most negative value, wraparound at the top of the address space, the behaviour of the unused codes, and a link that is written on a branch that is not taken. The bench compares all of these each clock against its own model.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [3:0] {
    CT_SEQ    = 4'd0,
    CT_BEQ    = 4'd1,
    CT_BNE    = 4'd2,
    CT_BLEZ   = 4'd3,
    CT_BGTZ   = 4'd4,
    CT_BLTZ   = 4'd5,
    CT_BGEZ   = 4'd6,
    CT_BLTZAL = 4'd7,
    CT_BGEZAL = 4'd8,
    CT_JMP    = 4'd9,
    CT_JAL    = 4'd10,
    CT_JR     = 4'd11,
    CT_JALR   = 4'd12
  } ct_op_e;

  localparam int CT_OP_W = 4;
endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  ct_op_e            op,
  input  logic [XLEN-1:0]   rs,
  input  logic [XLEN-1:0]   rt,
  output logic              cond
);
  logic rs_neg;
  logic rs_zero;
  logic regs_eq;

  assign rs_neg  = rs[XLEN-1];
  assign rs_zero = (rs == '0);
  assign regs_eq = (rs == rt);

  always_comb begin
    case (op)
      CT_BEQ:              cond = regs_eq;
      CT_BNE:              cond = !regs_eq;
      CT_BLEZ:             cond = rs_neg || rs_zero;
      CT_BGTZ:             cond = !rs_neg && !rs_zero;
      CT_BLTZ, CT_BLTZAL:  cond = rs_neg;
      CT_BGEZ, CT_BGEZAL:  cond = !rs_neg;
      default:             cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int IDX_W = 26
) (
  input  ct_op_e            op,
  input  logic              cond,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   rs,
  input  logic [OFF_W-1:0]  br_off,
  input  logic [IDX_W-1:0]  j_idx,
  output logic [XLEN-1:0]   nxt,
  output logic              tk
);
  localparam int SEXT_W = XLEN - OFF_W - 2;
  localparam int REG_HI = XLEN - IDX_W - 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] disp;
  logic [XLEN-1:0] br_pc;
  logic [XLEN-1:0] jmp_pc;

  assign seq_pc = pc + STEP;
  assign disp   = {{SEXT_W{br_off[OFF_W-1]}}, br_off, 2'b00};
  assign br_pc  = seq_pc + disp;
  assign jmp_pc = {pc[XLEN-1 -: REG_HI], j_idx, 2'b00};

  always_comb begin
    case (op)
      CT_BEQ, CT_BNE, CT_BLEZ, CT_BGTZ,
      CT_BLTZ, CT_BGEZ, CT_BLTZAL, CT_BGEZAL: begin
        tk  = cond;
        nxt = cond ? br_pc : seq_pc;
      end
      CT_JMP, CT_JAL: begin
        tk  = 1'b1;
        nxt = jmp_pc;
      end
      CT_JR, CT_JALR: begin
        tk  = 1'b1;
        nxt = rs;
      end
      default: begin
        tk  = 1'b0;
        nxt = seq_pc;
      end
    endcase
  end
endmodule

// File: rtl/npc_link.sv
module npc_link
  import npc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int REG_W    = 5,
  parameter int LINK_REG = 31
) (
  input  ct_op_e            op,
  input  logic [XLEN-1:0]   pc,
  input  logic [REG_W-1:0]  rd_idx,
  output logic              we,
  output logic [REG_W-1:0]  idx,
  output logic [XLEN-1:0]   val
);
  localparam logic [XLEN-1:0]  RET_STEP = XLEN'(8);
  localparam logic [REG_W-1:0] RA_IDX   = REG_W'(LINK_REG);

  assign val = pc + RET_STEP;

  always_comb begin
    case (op)
      CT_BLTZAL, CT_BGEZAL, CT_JAL: begin
        we  = 1'b1;
        idx = RA_IDX;
      end
      CT_JALR: begin
        we  = 1'b1;
        idx = rd_idx;
      end
      default: begin
        we  = 1'b0;
        idx = '0;
      end
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int OFF_W    = 16,
  parameter int IDX_W    = 26,
  parameter int REG_W    = 5,
  parameter int LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [XLEN-1:0]   rt_val,
  input  logic [OFF_W-1:0]  br_off,
  input  logic [IDX_W-1:0]  j_idx,
  input  logic [REG_W-1:0]  rd_idx,
  output logic              out_valid,
  output logic [XLEN-1:0]   next_pc,
  output logic              taken,
  output logic              link_we,
  output logic [REG_W-1:0]  link_idx,
  output logic [XLEN-1:0]   link_val
);
  ct_op_e            op_e;
  logic              cond_w;
  logic [XLEN-1:0]   nxt_w;
  logic              tk_w;
  logic              lwe_w;
  logic [REG_W-1:0]  lidx_w;
  logic [XLEN-1:0]   lval_w;

  assign op_e = ct_op_e'(op);

  npc_cond #(.XLEN(XLEN)) cond_i (
    .op   (op_e),
    .rs   (rs_val),
    .rt   (rt_val),
    .cond (cond_w)
  );

  npc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) tgt_i (
    .op     (op_e),
    .cond   (cond_w),
    .pc     (pc),
    .rs     (rs_val),
    .br_off (br_off),
    .j_idx  (j_idx),
    .nxt    (nxt_w),
    .tk     (tk_w)
  );

  npc_link #(.XLEN(XLEN), .REG_W(REG_W), .LINK_REG(LINK_REG)) lnk_i (
    .op     (op_e),
    .pc     (pc),
    .rd_idx (rd_idx),
    .we     (lwe_w),
    .idx    (lidx_w),
    .val    (lval_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      next_pc   <= '0;
      taken     <= 1'b0;
      link_we   <= 1'b0;
      link_idx  <= '0;
      link_val  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        next_pc  <= nxt_w;
        taken    <= tk_w;
        link_we  <= lwe_w;
        link_idx <= lidx_w;
        link_val <= lval_w;
      end
    end
  end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int XLEN     = 32,
  parameter int OFF_W    = 16,
  parameter int IDX_W    = 26,
  parameter int REG_W    = 5,
  parameter int LINK_REG = 31
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [3:0]        op,
  input logic [XLEN-1:0]   pc,
  input logic [XLEN-1:0]   rs_val,
  input logic [XLEN-1:0]   rt_val,
  input logic [OFF_W-1:0]  br_off,
  input logic [IDX_W-1:0]  j_idx,
  input logic [REG_W-1:0]  rd_idx,
  input logic              out_valid,
  input logic [XLEN-1:0]   next_pc,
  input logic              taken,
  input logic              link_we,
  input logic [REG_W-1:0]  link_idx,
  input logic [XLEN-1:0]   link_val
);
  logic ra_link;
  assign ra_link = (op == 4'd7) || (op == 4'd8) || (op == 4'd10);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !out_valid && !taken && !link_we && next_pc == '0 && link_val == '0); // R1

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_valid == $past(in_valid)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(next_pc) && $stable(taken) && $stable(link_we) && $stable(link_val)); // R2

  AST_EQ_DECIDES: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == 4'd1 |=> taken == ($past(rs_val) == $past(rt_val))); // R4

  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
    in_valid && (op == 4'd9 || op == 4'd10) |=> taken && next_pc[XLEN-1 -: 4] == $past(pc[XLEN-1 -: 4])); // R6

  AST_REG_JUMP: assert property (@(posedge clk) disable iff (rst)
    in_valid && (op == 4'd11 || op == 4'd12) |=> taken && next_pc == $past(rs_val)); // R7

  AST_RA_LINK: assert property (@(posedge clk) disable iff (rst)
    in_valid && ra_link |=> link_we && link_idx == REG_W'(LINK_REG) && link_val == $past(pc) + XLEN'(8)); // R8

  AST_NO_LINK: assert property (@(posedge clk) disable iff (rst)
    in_valid && !ra_link && op != 4'd12 |=> !link_we); // R9
endmodule

bind npc_unit npc_unit_chk #(
  .XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W), .REG_W(REG_W), .LINK_REG(LINK_REG)
) chk_i (.*);

// File: tb/npc_unit_tb_top.sv
`timescale 1ns/1ps
module npc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] pc = '0, rs_val = '0, rt_val = '0;
  logic [15:0] br_off = '0;
  logic [25:0] j_idx = '0;
  logic [4:0]  rd_idx = '0;
  logic        out_valid, taken, link_we;
  logic [31:0] next_pc, link_val;
  logic [4:0]  link_idx;

  int n_checks = 0;
  int n_fail = 0;

  logic        e_valid = 0, e_tk = 0, e_lwe = 0;
  logic [31:0] e_npc = 0, e_lval = 0;
  logic [4:0]  e_lidx = 0;

  always #2.5 clk = ~clk;

  npc_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .pc(pc),
    .rs_val(rs_val), .rt_val(rt_val), .br_off(br_off), .j_idx(j_idx),
    .rd_idx(rd_idx), .out_valid(out_valid), .next_pc(next_pc),
    .taken(taken), .link_we(link_we), .link_idx(link_idx), .link_val(link_val)
  );

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd1, 4'd2:             return "R4";
      4'd3, 4'd4, 4'd5, 4'd6: return "R5";
      4'd7, 4'd8:             return "R8";
      4'd9, 4'd10:            return "R6";
      4'd11, 4'd12:           return "R7";
      default:                return "R9";
    endcase
  endfunction

  task automatic compare(input string tag);
    logic [71:0] act, exp;
    act = {out_valid, next_pc, taken, link_we, link_idx, link_val};
    exp = {e_valid, e_npc, e_tk, e_lwe, e_lidx, e_lval};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act v=%b npc=%h tk=%b we=%b idx=%0d lv=%h exp v=%b npc=%h tk=%b we=%b idx=%0d lv=%h",
               tag, out_valid, next_pc, taken, link_we, link_idx, link_val,
               e_valid, e_npc, e_tk, e_lwe, e_lidx, e_lval);
    end
  endtask

  // Behavioural model: called at the posedge with the inputs of that cycle
  task automatic model();
    logic [31:0] seq, tgt;
    logic c;
    e_valid = in_valid;
    if (!in_valid) return;
    seq = pc + 32'd4;
    tgt = seq + 32'($signed(br_off) * 4);
    c = 1'b0;
    case (op)
      4'd1: c = (rs_val == rt_val);
      4'd2: c = (rs_val != rt_val);
      4'd3: c = ($signed(rs_val) <= 0);
      4'd4: c = ($signed(rs_val) > 0);
      4'd5, 4'd7: c = ($signed(rs_val) < 0);
      4'd6, 4'd8: c = ($signed(rs_val) >= 0);
      default: c = 1'b0;
    endcase
    e_lwe = 0; e_lidx = 0; e_lval = pc + 32'd8;
    if (op >= 4'd1 && op <= 4'd8) begin
      e_tk = c; e_npc = c ? tgt : seq;
    end else if (op == 4'd9 || op == 4'd10) begin
      e_tk = 1; e_npc = {pc[31:28], j_idx, 2'b00};
    end else if (op == 4'd11 || op == 4'd12) begin
      e_tk = 1; e_npc = rs_val;
    end else begin
      e_tk = 0; e_npc = seq;
    end
    if (op == 4'd7 || op == 4'd8 || op == 4'd10) begin e_lwe = 1; e_lidx = 5'd31; end
    if (op == 4'd12) begin e_lwe = 1; e_lidx = rd_idx; end
  endtask

  // Starts just after a negedge: drive, model at posedge, compare at negedge
  task automatic step(input bit v, input logic [3:0] o, input logic [31:0] p,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] off, input logic [25:0] ji,
                      input logic [4:0] rd, input string tag);
    in_valid = v; op = o; pc = p; rs_val = a; rt_val = b;
    br_off = off; j_idx = ji; rd_idx = rd;
    @(posedge clk);
    model();
    @(negedge clk);
    compare(tag == "" ? tag_of(o) : tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst = 1; in_valid = 1; op = 4'd10; pc = 32'h1234_5678; rs_val = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst = 0;

    step(1, 4'd0, 32'h0000_1000, 0, 0, 16'h0, 0, 0, "");
    step(1, 4'd1, 32'h0000_2000, 32'd5, 32'd5, 16'h0010, 0, 0, "R3");
    step(1, 4'd1, 32'h0000_2000, 32'd5, 32'd6, 16'h0010, 0, 0, "R3");
    step(1, 4'd2, 32'h0000_3000, 32'd5, 32'd6, 16'hFFFF, 0, 0, "");
    step(1, 4'd2, 32'h0000_3000, 32'd0, 32'd0, 16'h0004, 0, 0, "R4");
    step(1, 4'd2, 32'h0000_3000, 32'd9, 32'd0, 16'h7FFF, 0, 0, "R3");
    step(1, 4'd1, 32'h0004_0000, 32'd1, 32'd1, 16'h8000, 0, 0, "R3");
    step(1, 4'd3, 32'h100, 32'd0, 0, 16'h0020, 0, 0, "");
    step(1, 4'd3, 32'h100, 32'hFFFF_FFFF, 0, 16'h0020, 0, 0, "");
    step(1, 4'd3, 32'h100, 32'd1, 0, 16'h0020, 0, 0, "");
    step(1, 4'd4, 32'h100, 32'd0, 0, 16'h0020, 0, 0, "");
    step(1, 4'd4, 32'h100, 32'h7FFF_FFFF, 0, 16'h0020, 0, 0, "");
    step(1, 4'd5, 32'h100, 32'h8000_0000, 0, 16'hFFF0, 0, 0, "");
    step(1, 4'd5, 32'h100, 32'd0, 0, 16'hFFF0, 0, 0, "");
    step(1, 4'd6, 32'h100, 32'd0, 0, 16'h0008, 0, 0, "");
    step(1, 4'd6, 32'h100, 32'h8000_0000, 0, 16'h0008, 0, 0, "");
    step(1, 4'd7, 32'h0040_0000, 32'd3, 0, 16'h0008, 0, 0, "R8");
    step(1, 4'd7, 32'h0040_0000, 32'hFFFF_FF00, 0, 16'h0008, 0, 0, "R8");
    step(1, 4'd8, 32'h0040_0010, 32'hFFFF_FF00, 0, 16'h0008, 0, 0, "R8");
    step(1, 4'd9, 32'hA000_0040, 0, 0, 16'h0, 26'h3FF_FFFF, 0, "R6");
    step(1, 4'd10, 32'h5FFF_FFF0, 0, 0, 16'h0, 26'h000_0123, 0, "R6");
    step(0, 4'd11, 32'h0, 32'hDEAD_BEEF, 0, 16'h0, 0, 0, "R2");
    step(0, 4'd0, 32'h0, 32'h0, 0, 16'h0, 0, 0, "R2");
    step(1, 4'd11, 32'h0000_0400, 32'hDEAD_BEE0, 0, 16'h0, 0, 5'd9, "R7");
    step(1, 4'd12, 32'h0000_0400, 32'h0000_8000, 0, 16'h0, 0, 5'd7, "R7");
    step(1, 4'd13, 32'h0000_0500, 32'd1, 32'd1, 16'h0010, 26'h1, 5'd3, "R9");
    step(1, 4'd15, 32'h0000_0500, 32'd1, 32'd1, 16'h0010, 26'h1, 5'd3, "R9");
    step(1, 4'd0, 32'hFFFF_FFFC, 0, 0, 16'h0, 0, 0, "R10");
    step(1, 4'd10, 32'hFFFF_FFFC, 0, 0, 16'h0, 26'h5, 0, "R10");
    step(1, 4'd1, 32'hFFFF_FFF8, 32'd2, 32'd2, 16'h0002, 0, 0, "R10");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [3:0] o;
      o = 4'($urandom_range(0, 15));
      a = (i % 4 == 0) ? 32'($urandom_range(0, 2)) - 32'd1 : $urandom();
      step(($urandom_range(0, 4) != 0), o, $urandom(), a,
           (i % 3 == 0) ? a : $urandom(), 16'($urandom()), 26'($urandom()),
           5'($urandom()), "");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule